// File: doc/BRIEF.md
# Debug system bus access engine

This block lets a debug host read and write system memory without the processor's help. The host works through three word-wide registers: a control/status word, an address word and a data word. Writing the data word starts a bus write. Writing the address word, or reading the data word, can start a bus read when the matching trigger flag is set. After each successful access the address can step forward by the access size. A busy bit tracks the access in flight. Two sticky error flags record host misuse and bus failures, and while either is set no new access may start.

The engine shares one load/store bus port with the processor's data accesses. The core always wins a contested cycle. A debug access goes onto the bus only when no core transfer is in its address phase, and once on the bus it holds its request until granted. At most one transfer is outstanding, and each response goes back to the side that issued it. The whole block, including the arbitration, runs on an always-on clock and has no core-clock input. Debug accesses therefore keep moving while the processor's clock is gated in sleep.

Top module: `dbg_bus_bridge`

## Requirements
- R1: After reset the control word, the address word and the data word all read 0, and `bus_req` is low. Register select codes: 0 = control, 1 = address, 2 = data, 3 = reads 0. Control bits: [0] busy (read-only), [1] busy error, [4:2] error code, [5] auto-increment, [6] read on address write, [7] read on data read, [9:8] size (0 = 8 bit, 1 = 16 bit, 2 = 32 bit).
- R2: When both error flags are clear and the engine is idle, a data write starts a bus write of the new data at the address word. With the trigger flag set, an address write starts a bus read at the new address, and a data read starts a bus read at the current address. Read data is zero-extended from its low size bits into the data word.
- R3: The busy bit is 1 from the cycle after the triggering register access until the cycle after the bus response for that access.
- R4: After a successful access with auto-increment set, the address word grows by 1, 2 or 4 for sizes 0, 1 and 2. The size and increment setting used are those in force when the access started.
- R5: A bus response with the error flag set loads error code 2 and leaves the address word unchanged.
- R6: An address write, a data write or a data read while busy sets the busy error, and neither the address word nor the data word takes the written value.
- R7: A data write while either error flag is set is ignored: the data word keeps its value and no bus access starts.
- R8: Neither read trigger starts a bus access while either error flag is set.
- R9: A control write clears the busy error when bit 1 is 1, and clears each error-code bit where bits [4:2] of the written value are 1.
- R10: A debug request goes onto the bus only in a cycle with `core_req` low. A request left ungranted keeps `bus_req` and `bus_addr` unchanged in the next cycle. At most one transfer is outstanding, and `core_rsp_valid` pulses only for responses to core transfers.
- R11: A size value of 3 written to the control word is stored as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Host register select |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for the selected register |
| core_req | input | 1 | Core transfer request, held until granted |
| core_wr | input | 1 | Core transfer is a write |
| core_size | input | 2 | Core transfer size code |
| core_addr | input | ADDR_W | Core transfer address |
| core_wdata | input | 32 | Core write data |
| core_gnt | output | 1 | Core request accepted by the bus |
| core_rsp_valid | output | 1 | Response for a core transfer |
| core_rdata | output | 32 | Core read data |
| core_err | output | 1 | Core transfer bus error |
| bus_req | output | 1 | Shared port request |
| bus_wr | output | 1 | Shared port write |
| bus_size | output | 2 | Shared port size code |
| bus_addr | output | ADDR_W | Shared port address |
| bus_wdata | output | 32 | Shared port write data |
| bus_gnt | input | 1 | Shared port grant |
| bus_rsp_valid | input | 1 | Shared port response |
| bus_rdata | input | 32 | Shared port read data |
| bus_err | input | 1 | Shared port response error |

## Verification
The bench builds the block with the default 32-bit address. With that width, a full-word address region whose top nibble is all ones can act as a bus-error window, separate from the debug and core regions. The bus model in the bench grants after random delays, returns responses after random latencies, and runs random core traffic alongside random debug reads and writes at every size. This brings contested arbitration, stalled address phases and auto-increment across all three sizes within reach of the checks.

// File: rtl/dbg_bus_bridge.sv
module dbg_bus_bridge #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_aon,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              core_req,
  input  logic              core_wr,
  input  logic [1:0]        core_size,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [31:0]       core_wdata,
  output logic              core_gnt,
  output logic              core_rsp_valid,
  output logic [31:0]       core_rdata,
  output logic              core_err,
  output logic              bus_req,
  output logic              bus_wr,
  output logic [1:0]        bus_size,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_rsp_valid,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_err
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [2:0] ERR_BUS  = 3'd2;

  logic              busy_err_q, autoinc_q, rd_addr_q, rd_data_q;
  logic [2:0]        err_q;
  logic [1:0]        size_q, dbg_size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q, rd_masked;
  logic              dbg_req_q, dbg_wr_q, dbg_inc_q, dbg_drv_q;
  logic              pend_q, pend_dbg_q;

  wire wr_ctrl  = reg_wr && reg_sel == SEL_CTRL;
  wire wr_addr  = reg_wr && reg_sel == SEL_ADDR;
  wire wr_data  = reg_wr && reg_sel == SEL_DATA;
  wire rd_data  = reg_rd && reg_sel == SEL_DATA;
  wire busy     = dbg_req_q || (pend_q && pend_dbg_q);
  wire clean    = !busy_err_q && err_q == 3'd0;
  wire busy_hit = busy && (wr_addr || wr_data || rd_data);
  wire start_rd = !busy && clean && ((wr_addr && rd_addr_q) || (rd_data && rd_data_q));
  wire start_wr = !busy && clean && wr_data;
  wire dbg_on   = dbg_req_q && (dbg_drv_q || !core_req);
  wire dbg_done = bus_rsp_valid && pend_q && pend_dbg_q;
  wire [ADDR_W-1:0] incr = ADDR_W'(1) << dbg_size_q;

  assign bus_req   = !pend_q && (dbg_on || core_req);
  assign bus_wr    = dbg_on ? dbg_wr_q   : core_wr;
  assign bus_size  = dbg_on ? dbg_size_q : core_size;
  assign bus_addr  = dbg_on ? addr_q     : core_addr;
  assign bus_wdata = dbg_on ? data_q     : core_wdata;
  assign core_gnt       = bus_gnt && core_req && !dbg_on && !pend_q;
  assign core_rsp_valid = bus_rsp_valid && pend_q && !pend_dbg_q;
  assign core_rdata     = bus_rdata;
  assign core_err       = bus_err;

  always_comb begin
    case (dbg_size_q)
      2'd0:    rd_masked = {24'd0, bus_rdata[7:0]};
      2'd1:    rd_masked = {16'd0, bus_rdata[15:0]};
      default: rd_masked = bus_rdata;
    endcase
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {22'd0, size_q, rd_data_q, rd_addr_q, autoinc_q, err_q, busy_err_q, busy};
      SEL_ADDR: reg_rdata = 32'(addr_q);
      SEL_DATA: reg_rdata = data_q;
      default:  reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk_aon or negedge rst_n) begin
    if (!rst_n) begin
      busy_err_q <= 1'b0;
      err_q      <= 3'd0;
      autoinc_q  <= 1'b0;
      rd_addr_q  <= 1'b0;
      rd_data_q  <= 1'b0;
      size_q     <= 2'd0;
      addr_q     <= '0;
      data_q     <= 32'd0;
      dbg_req_q  <= 1'b0;
      dbg_wr_q   <= 1'b0;
      dbg_inc_q  <= 1'b0;
      dbg_size_q <= 2'd0;
      dbg_drv_q  <= 1'b0;
      pend_q     <= 1'b0;
      pend_dbg_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        autoinc_q <= reg_wdata[5];
        rd_addr_q <= reg_wdata[6];
        rd_data_q <= reg_wdata[7];
        size_q    <= (reg_wdata[9:8] == 2'd3) ? 2'd2 : reg_wdata[9:8];
      end
      if (busy_hit)
        busy_err_q <= 1'b1;
      else if (wr_ctrl && reg_wdata[1])
        busy_err_q <= 1'b0;
      if (dbg_done && bus_err)
        err_q <= ERR_BUS;
      else if (wr_ctrl)
        err_q <= err_q & ~reg_wdata[4:2];
      if (wr_addr && !busy)
        addr_q <= reg_wdata[ADDR_W-1:0];
      else if (dbg_done && !bus_err && dbg_inc_q)
        addr_q <= addr_q + incr;
      if (start_wr)
        data_q <= reg_wdata;
      else if (dbg_done && !bus_err && !dbg_wr_q)
        data_q <= rd_masked;
      if (start_rd || start_wr) begin
        dbg_req_q  <= 1'b1;
        dbg_wr_q   <= start_wr;
        dbg_size_q <= size_q;
        dbg_inc_q  <= autoinc_q;
      end else if (dbg_on && bus_gnt && !pend_q) begin
        dbg_req_q <= 1'b0;
      end
      dbg_drv_q <= dbg_on && !pend_q && !bus_gnt;
      if (bus_req && bus_gnt) begin
        pend_q     <= 1'b1;
        pend_dbg_q <= dbg_on;
      end else if (bus_rsp_valid && pend_q) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R3
  busy_clear_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    dbg_done |=> !reg_rdata[0] || reg_sel != SEL_CTRL);
  // R5
  err_noinc_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    dbg_done && bus_err |=> $stable(addr_q) && err_q == ERR_BUS);
  // R6
  busy_err_set_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    busy && (wr_addr || wr_data) |=> busy_err_q && $stable(addr_q));
  // R7
  data_hold_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    wr_data && !busy && !clean |=> $stable(data_q) && !dbg_req_q);
  // R10
  aphase_hold_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    bus_req && !bus_gnt && (dbg_on || core_req) |=> bus_req && $stable(bus_addr));
  // R10
  core_first_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    $rose(dbg_drv_q) |-> !$past(core_req));
  // R10
  one_out_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
    pend_q |-> !bus_req && !core_gnt);
endmodule

// File: tb/dbg_bus_bridge_test.sv
module dbg_bus_bridge_test;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [1:0]  reg_sel = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        core_req = 0, core_wr = 0;
  logic [1:0]  core_size = 2;
  logic [31:0] core_addr = 0, core_wdata = 0;
  logic        core_gnt, core_rsp_valid, core_err;
  logic [31:0] core_rdata;
  logic        bus_req, bus_wr;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata;
  logic        bus_gnt = 0, bus_rsp_valid = 0, bus_err = 0;
  logic [31:0] bus_rdata = 0;

  dbg_bus_bridge #(.ADDR_W(32)) uut (
    .clk_aon(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_req(core_req), .core_wr(core_wr),
    .core_size(core_size), .core_addr(core_addr), .core_wdata(core_wdata), .core_gnt(core_gnt),
    .core_rsp_valid(core_rsp_valid), .core_rdata(core_rdata), .core_err(core_err),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_gnt(bus_gnt), .bus_rsp_valid(bus_rsp_valid),
    .bus_rdata(bus_rdata), .bus_err(bus_err));

  int checks = 0, fails = 0, dbg_txn = 0;
  bit hold_gnt = 0, core_new = 0, core_acc = 0, core_wait = 0;
  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    return sz == 0 ? 32'hFF : sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] next_addr(input logic [31:0] a, input logic [1:0] sz, input bit ai);
    return ai ? a + (32'd1 << sz) : a;
  endfunction
  function automatic logic [31:0] ctrl_word(input logic [1:0] sz, input bit rdd, input bit rda, input bit ai);
    return {22'd0, sz, rdd, rda, ai, 5'd0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus responder: grant after #1 past the falling edge, respond a few cycles later
  initial begin
    bit inflight = 0, rwr = 0;
    int lat = 0;
    logic [31:0] ra = 0;
    logic [1:0] rsz = 0;
    forever begin
      @(negedge clk); #1;
      bus_rsp_valid = 0; bus_err = 0;
      if (inflight) begin
        if (lat == 0) begin
          bus_rsp_valid = 1;
          bus_err = ra[31:28] == 4'hF;
          if (!rwr) bus_rdata = mem.exists(ra) ? mem[ra] : (ra ^ 32'h5A5A_5A5A);
          inflight = 0;
        end else lat--;
      end
      bus_gnt = bus_req && !hold_gnt && ($urandom % 4 != 0);
      if (bus_gnt) begin
        inflight = 1; lat = $urandom % 3; ra = bus_addr; rwr = bus_wr; rsz = bus_size;
        if (ra[31:28] != 4'h2) dbg_txn++;
        if (rwr && ra[31:28] != 4'hF) mem[ra] = bus_wdata & size_mask(rsz);
      end
    end
  end

  // core traffic driver
  initial forever begin
    @(negedge clk);
    if (core_acc) begin core_req = 0; core_acc = 0; end
    else if (core_new && !core_req && $urandom % 3 == 0) begin
      core_req = 1; core_wr = $urandom; core_size = 2;
      core_addr = 32'h2000_0000 | ($urandom & 32'hFC); core_wdata = $urandom;
    end
    #2;
    if (core_req && core_gnt) core_acc = 1;
  end

  // core response routing monitor
  initial forever begin
    @(negedge clk); #2;
    if (core_rsp_valid) begin
      chk(core_wait, "R10 core response without core transfer", 32'(core_rsp_valid), 32'(core_wait));
      core_wait = 0;
    end
    if (core_req && core_gnt) core_wait = 1;
  end

  task automatic host_wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask
  task automatic host_rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk); reg_sel = sel; reg_rd = 1; #2; d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask
  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); reg_sel = 0; #2; v = reg_rdata;
      if (!v[0]) break;
    end
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a, d, exp_a;
    logic [1:0] sz;
    bit ai;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    host_rd(0, v); chk(v == 0, "R1 control after reset", v, 0);
    host_rd(1, v); chk(v == 0, "R1 address after reset", v, 0);
    host_rd(2, v); chk(v == 0, "R1 data after reset", v, 0);
    host_rd(3, v); chk(v == 0, "R1 unused select", v, 0);
    chk(!bus_req, "R1 bus idle after reset", 32'(bus_req), 0);

    // R11 size clamp
    host_wr(0, {22'd0, 2'd3, 8'd0}); host_rd(0, v);
    chk(v[9:8] == 2, "R11 size 3 stored as 2", 32'(v[9:8]), 2);

    // R3 busy window
    hold_gnt = 1;
    host_wr(0, ctrl_word(2, 0, 0, 0));
    host_wr(1, 32'h1000_0100);
    host_wr(2, 32'hCAFE_0001);
    host_rd(0, v); chk(v[0] == 1, "R3 busy while awaiting grant", 32'(v[0]), 1);
    hold_gnt = 0; wait_idle();
    host_rd(0, v); chk(v[0] == 0, "R3 busy clears after response", 32'(v[0]), 0);
    chk(mem[32'h1000_0100] == 32'hCAFE_0001, "R2 directed write reaches memory", mem[32'h1000_0100], 32'hCAFE_0001);

    // R5 bus error, R7 write ignored, R8 trigger blocked, R9 clear
    host_wr(0, ctrl_word(2, 0, 0, 1));
    host_wr(1, 32'hF000_0000);
    host_wr(2, 32'h0000_1234); wait_idle();
    host_rd(0, v); chk(v[4:2] == 2, "R5 error code after bus error", 32'(v[4:2]), 2);
    host_rd(1, v); chk(v == 32'hF000_0000, "R5 no increment on bus error", v, 32'hF000_0000);
    t0 = dbg_txn;
    host_wr(2, 32'h0000_ABCD); repeat (4) @(negedge clk);
    host_rd(2, v); chk(v == 32'h1234, "R7 data write ignored under error", v, 32'h1234);
    chk(dbg_txn == t0, "R7 no access under error", dbg_txn, t0);
    host_wr(0, ctrl_word(2, 1, 1, 0));
    host_wr(1, 32'h1000_0010); host_rd(2, v); repeat (4) @(negedge clk);
    chk(dbg_txn == t0, "R8 read triggers blocked under error", dbg_txn, t0);
    host_wr(0, ctrl_word(2, 0, 0, 0) | 32'h1C); host_rd(0, v);
    chk(v[4:2] == 0, "R9 error code cleared", 32'(v[4:2]), 0);

    // R6 busy error, R8 under busy error, R9
    hold_gnt = 1;
    host_wr(0, ctrl_word(2, 0, 1, 0));
    host_wr(1, 32'h1000_0020);
    host_wr(1, 32'h1000_0040);
    host_rd(0, v); chk(v[1] == 1, "R6 busy error on address write", 32'(v[1]), 1);
    hold_gnt = 0; wait_idle();
    host_rd(1, v); chk(v == 32'h1000_0020, "R6 address kept on busy write", v, 32'h1000_0020);
    t0 = dbg_txn;
    host_wr(1, 32'h1000_0030); repeat (4) @(negedge clk);
    chk(dbg_txn == t0, "R8 address trigger blocked under busy error", dbg_txn, t0);
    host_wr(0, ctrl_word(2, 0, 0, 0) | 32'h2); host_rd(0, v);
    chk(v[1] == 0, "R9 busy error cleared", 32'(v[1]), 0);
    hold_gnt = 1;
    host_wr(2, 32'h7777_0000);
    host_wr(2, 32'h8888_0000);
    hold_gnt = 0; wait_idle();
    host_rd(2, v); chk(v == 32'h7777_0000, "R6 data kept on busy data write", v, 32'h7777_0000);
    host_rd(0, v); chk(v[1] == 1, "R6 busy error on data write", 32'(v[1]), 1);
    host_wr(0, 32'h2);

    // R10 core priority and held address phase
    hold_gnt = 1;
    @(negedge clk); core_req = 1; core_wr = 0; core_addr = 32'h2000_0100;
    host_wr(0, ctrl_word(2, 0, 0, 0));
    host_wr(1, 32'h1000_0080);
    host_wr(2, 32'h5555_AAAA);
    @(negedge clk); #2;
    chk(bus_addr == 32'h2000_0100, "R10 core wins contested port", bus_addr, 32'h2000_0100);
    hold_gnt = 0; wait_idle(); repeat (6) @(negedge clk);
    chk(mem[32'h1000_0080] == 32'h5555_AAAA, "R10 debug write after core", mem[32'h1000_0080], 32'h5555_AAAA);
    hold_gnt = 1;
    host_wr(2, 32'h6666_BBBB);
    @(negedge clk); core_req = 1; core_wr = 0; core_addr = 32'h2000_0104;
    @(negedge clk); #2;
    chk(bus_addr == 32'h1000_0080, "R10 debug address phase held", bus_addr, 32'h1000_0080);
    hold_gnt = 0; wait_idle(); repeat (6) @(negedge clk);

    // R2/R4 read on data read with auto-increment
    mem[32'h1000_0200] = 32'hAAAA_0001; mem[32'h1000_0204] = 32'hBBBB_0002;
    host_wr(0, ctrl_word(2, 1, 1, 1));
    host_wr(1, 32'h1000_0200); wait_idle();
    host_rd(2, v); chk(v == 32'hAAAA_0001, "R2 read on address write", v, 32'hAAAA_0001);
    wait_idle();
    host_rd(2, v); chk(v == 32'hBBBB_0002, "R2 read on data read", v, 32'hBBBB_0002);
    wait_idle();
    host_rd(1, v); chk(v == 32'h1000_020C, "R4 three increments of 4", v, 32'h1000_020C);

    // random mix with core traffic
    core_new = 1;
    for (int n = 0; n < 300; n++) begin
      sz = 2'($urandom % 3); ai = $urandom;
      a = (32'h1000_0000 | ($urandom & 32'h3FC)) & ~((32'd1 << sz) - 1);
      d = $urandom;
      exp_a = next_addr(a, sz, ai);
      if ($urandom % 2) begin
        host_wr(0, ctrl_word(sz, 0, 0, ai));
        host_wr(1, a); host_wr(2, d); wait_idle();
        chk(mem[a] == (d & size_mask(sz)), "R2 random write", mem[a], d & size_mask(sz));
      end else begin
        host_wr(0, ctrl_word(sz, 0, 1, ai));
        host_wr(1, a); wait_idle();
        host_rd(2, v);
        d = (mem.exists(a) ? mem[a] : (a ^ 32'h5A5A_5A5A)) & size_mask(sz);
        chk(v == d, "R2 random read", v, d);
      end
      host_rd(1, v); chk(v == exp_a, "R4 random address step", v, exp_a);
    end
    core_new = 0;
    repeat (20) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule